// File: doc/BRIEF.md
# Scanned Dot-Matrix Glyph Generator

This block stores a small font for a dot-matrix display and reads it out one row at a time. A 6-bit character code picks one of 64 glyphs. Each glyph is 8 rows high and 5 dots wide. A free-running row counter walks through the rows of the selected glyph, one row per clock. On each clock the block presents the 5-dot pattern of one row, together with that row's index. A pulse marks the first row of every scan.

The lookup address is the character code in the upper bits joined to the 3-bit row count in the lower bits. The character code is taken only when the row count is 0, so a change on the input during a scan takes effect at the next scan. The read is registered, which keeps the dot pattern, the row index and the start pulse aligned on the same cycle. Four glyphs are defined, and every other code shows a filler pattern.

Top module: `glyph_scan_gen`

## Requirements
- R1: While the synchronous active-high reset is sampled high at a clock edge, the outputs after that edge are `row_idx` = 0, `dots` = 0 and `frame_start` = 0, and the internal row count returns to 0.
- R2: Outside reset, `row_idx` advances by one each clock, from 0 up to 7, and wraps from 7 back to 0. The first edge after reset outputs row 0.
- R3: From the second edge after reset onward, `frame_start` is 1 exactly on the cycles where `row_idx` is 0.
- R4: `char_code` is sampled only at the edge that reads row 0. A change on the input during rows 1 to 7 has no effect on `dots` until the next row-0 read.
- R5: `dots` is registered and shows the row that `row_idx` reports on the same cycle. It uses the code sampled for that scan, and it becomes visible one clock after the row was addressed.
- R6: Code 0 is blank: all 8 rows read 00000.
- R7: Code 1 is a solid block: all 8 rows read 11111.
- R8: Code 2 reads 11110, 10000, 10000, 11110, 10000, 10000, 11111 for rows 0 to 6, and 00000 for row 7. Bit 4 of `dots` is the leftmost column.
- R9: Code 3 is a centred bar: rows 0 to 6 read 00100 (only bit 2 set), and row 7 reads 00000.
- R10: Every code from 4 to 63 reads 10101 on even rows and 01010 on odd rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| char_code | input | 6 | Character to display, sampled at row 0 |
| dots | output | 5 | Dot pattern of the current row, bit 4 leftmost |
| row_idx | output | 3 | Row number that `dots` belongs to |
| frame_start | output | 1 | High on the cycle that presents row 0 |

## Verification
The bench builds the block with its default widths: a 6-bit code, a 3-bit row count and 5 dots. With these widths the whole 64-entry code space is small enough for random draws to reach every code, including all four defined glyphs, many times. The stimulus changes the code at random row positions and pulses reset in the middle of scans. This exercises the sampling at row 0, the hold during rows 1 to 7, and the restart from row 0 after reset.

// File: rtl/glyph_scan_gen.sv
module glyph_scan_gen #(
  parameter int CODE_W = 6,
  parameter int ROW_W  = 3,
  parameter int DOT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] char_code,
  output logic [DOT_W-1:0]  dots,
  output logic [ROW_W-1:0]  row_idx,
  output logic              frame_start
);
  localparam int ADDR_W = CODE_W + ROW_W;

  logic [ROW_W-1:0]  rcnt;
  logic [CODE_W-1:0] code_hold;
  logic [CODE_W-1:0] addr_code;
  logic [ADDR_W-1:0] rom_addr;
  logic [DOT_W-1:0]  rom_word;
  logic              at_top;

  assign at_top    = (rcnt == '0);
  assign addr_code = at_top ? char_code : code_hold;
  assign rom_addr  = {addr_code, rcnt};

  function automatic logic [DOT_W-1:0] glyph_row(input logic [ADDR_W-1:0] a);
    logic [CODE_W-1:0] c;
    logic [ROW_W-1:0]  r;
    logic [4:0]        w;
    c = a[ADDR_W-1:ROW_W];
    r = a[ROW_W-1:0];
    case (c)
      CODE_W'(0): w = 5'b00000;
      CODE_W'(1): w = 5'b11111;
      CODE_W'(2): begin
        case (r)
          3'd0, 3'd3: w = 5'b11110;
          3'd6:       w = 5'b11111;
          3'd7:       w = 5'b00000;
          default:    w = 5'b10000;
        endcase
      end
      CODE_W'(3): w = (r == 3'd7) ? 5'b00000 : 5'b00100;
      default:    w = r[0] ? 5'b01010 : 5'b10101;
    endcase
    return DOT_W'(w);
  endfunction

  assign rom_word = glyph_row(rom_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      rcnt        <= '0;
      code_hold   <= '0;
      dots        <= '0;
      row_idx     <= '0;
      frame_start <= 1'b0;
    end else begin
      rcnt        <= rcnt + 1'b1;
      code_hold   <= addr_code;
      dots        <= rom_word;
      row_idx     <= rcnt;
      frame_start <= at_top;
    end
  end
endmodule

// File: rtl/glyph_scan_gen_chk.sv
module glyph_scan_gen_chk #(
  parameter int CODE_W = 6,
  parameter int ROW_W  = 3,
  parameter int DOT_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [DOT_W-1:0]  dots,
  input logic [ROW_W-1:0]  row_idx,
  input logic              frame_start,
  input logic [ROW_W-1:0]  rcnt,
  input logic [CODE_W-1:0] code_hold
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (row_idx == '0 && dots == '0 && !frame_start && rcnt == '0));

  a_r2_row_steps: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> row_idx == ROW_W'($past(row_idx) + 1'b1));

  a_r3_frame_marks_top: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (frame_start == (row_idx == '0)));

  a_r4_code_held_mid_scan: assert property (@(posedge clk) disable iff (rst)
    (rcnt != '0) |=> $stable(code_hold));

  a_r5_row_tracks_count: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rcnt == ROW_W'(row_idx + 1'b1));
endmodule

bind glyph_scan_gen glyph_scan_gen_chk #(
  .CODE_W(CODE_W), .ROW_W(ROW_W), .DOT_W(DOT_W)
) u_chk (
  .clk(clk), .rst(rst), .dots(dots), .row_idx(row_idx),
  .frame_start(frame_start), .rcnt(rcnt), .code_hold(code_hold)
);

// File: tb/sim_glyph_scan_gen.sv
`timescale 1ns/1ps
module sim_glyph_scan_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] char_code = 6'd0;
  logic [4:0] dots;
  logic [2:0] row_idx;
  logic       frame_start;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  glyph_scan_gen u0 (
    .clk(clk), .rst(rst), .char_code(char_code),
    .dots(dots), .row_idx(row_idx), .frame_start(frame_start)
  );

  function automatic logic [4:0] exp_glyph(input logic [5:0] c, input logic [2:0] r);
    if (c == 6'd0) return 5'b00000;
    if (c == 6'd1) return 5'b11111;
    if (c == 6'd2) begin
      if (r == 3'd7) return 5'b00000;
      if (r == 3'd6) return 5'b11111;
      if (r == 3'd0 || r == 3'd3) return 5'b11110;
      return 5'b10000;
    end
    if (c == 6'd3) return (r == 3'd7) ? 5'b00000 : 5'b00100;
    return (r % 2 == 0) ? 5'b10101 : 5'b01010;
  endfunction

  function automatic string glyph_tag(input logic [5:0] c);
    if (c == 6'd0) return "R6";
    if (c == 6'd1) return "R7";
    if (c == 6'd2) return "R8";
    if (c == 6'd3) return "R9";
    return "R10";
  endfunction

  // reference model built from the requirements
  logic [2:0] m_row = 3'd0;
  logic [5:0] m_code = 6'd0;
  logic [4:0] e_dots = 5'd0;
  logic [2:0] e_row = 3'd0;
  logic       e_fs = 1'b0;
  logic [5:0] e_code = 6'd0;
  bit         e_reset = 1'b1;
  bit         e_torn = 1'b0;
  bit         torn_scan = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_row <= 3'd0; m_code <= 6'd0;
      e_dots <= 5'd0; e_row <= 3'd0; e_fs <= 1'b0;
      e_reset <= 1'b1; e_torn <= 1'b0; torn_scan <= 1'b0;
    end else begin
      logic [5:0] use_code;
      bit t;
      use_code = (m_row == 3'd0) ? char_code : m_code;
      t = (m_row == 3'd0) ? 1'b0 : (torn_scan || char_code != m_code);
      torn_scan <= t;
      m_code <= use_code;
      e_code <= use_code;
      e_dots <= exp_glyph(use_code, m_row);
      e_row  <= m_row;
      e_fs   <= (m_row == 3'd0);
      e_reset <= 1'b0;
      e_torn <= t;
      m_row  <= m_row + 3'd1;
    end
  end

  task automatic check_outputs();
    string tg;
    n_checks++;
    if (row_idx !== e_row) begin
      n_fail++;
      $display("FAIL %s row_idx actual=%0d expected=%0d", e_reset ? "R1" : "R2", row_idx, e_row);
    end
    n_checks++;
    if (frame_start !== e_fs) begin
      n_fail++;
      $display("FAIL %s frame_start actual=%0b expected=%0b", e_reset ? "R1" : "R3", frame_start, e_fs);
    end
    tg = e_reset ? "R1" : (e_torn ? "R4" : glyph_tag(e_code));
    n_checks++;
    if (dots !== e_dots) begin
      n_fail++;
      $display("FAIL %s/R5 dots code=%0d row=%0d actual=%b expected=%b", tg, e_code, e_row, dots, e_dots);
    end
  endtask

  task automatic step(input logic [5:0] c, input bit r);
    @(negedge clk);
    check_outputs();
    char_code = c;
    rst = r;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) step(6'd0, 1'b1);
    // directed: each defined glyph over two full scans (R6..R9), filler (R10)
    for (int g = 0; g < 6; g++) begin
      logic [5:0] c;
      c = (g < 4) ? 6'(g) : ((g == 4) ? 6'd4 : 6'd63);
      for (int k = 0; k < 16; k++) step(c, 1'b0);
    end
    // directed R4: change code in the middle of a scan
    for (int k = 0; k < 8; k++) step(6'd2, 1'b0);
    for (int k = 0; k < 3; k++) step(6'd2, 1'b0);
    for (int k = 0; k < 13; k++) step(6'd1, 1'b0);
    // directed R1: reset in the middle of a scan
    for (int k = 0; k < 3; k++) step(6'd3, 1'b0);
    step(6'd3, 1'b1);
    step(6'd3, 1'b1);
    for (int k = 0; k < 10; k++) step(6'd3, 1'b0);
    // random stimulus
    for (int k = 0; k < 4000; k++) begin
      logic [5:0] c;
      bit r;
      c = char_code;
      if ($urandom % 4 == 0) c = ($urandom % 2 == 0) ? 6'($urandom % 4) : 6'($urandom);
      r = ($urandom % 97 == 0);
      step(c, r);
    end
    step(char_code, 1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end
endmodule